// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Replay

This block is a 2048-word by 36-bit first-in first-out buffer. It carries data in one direction, from a write port to a read port. Each port runs on its own free-running clock. The two clocks may be unrelated or the same clock. A word moves only on a rising edge of its port's clock, and only when that port's enable is high. The write side shows `in_ready` and an active-low `almost_full_n`, both held in the write clock domain. The read side shows `out_ready` and an active-low `almost_empty_n`, both held in the read clock domain. Pointers cross between the domains in Gray code through two-flop synchronizers.

The two watermark offsets are picked with `load_mode` while reset is high:
- The default mode keeps both offsets at 8.
- The parallel mode takes the offsets from the first two accepted writes.
- The serial mode shifts the offsets in one bit per write clock.

A replay feature lets the consumer mark a read position and later rewind to it. While the mark is held, the writer cannot overwrite any word from the mark onward.

Top module: `dcfifo_rtx`

## Requirements
- R1: While `rst` is high, the block holds `in_ready`=0, `out_ready`=0, `almost_empty_n`=0 and `almost_full_n`=1. In the default mode (`load_mode`=2'b00 during reset), `in_ready` rises within a few write clocks after reset falls.
- R2: Words leave in the order they were written. A read (`rd_en` and `out_ready` high at a read-clock edge) updates `rd_data` at that edge with the oldest stored word.
- R3: After 2048 stored words, `in_ready` is 0. A write attempted while `in_ready` is 0 is ignored: the same 2048 words read back, and then the FIFO is empty.
- R4: `out_ready` is 0 when no word is stored. Holding `rd_en` high while `out_ready` is 0 leaves `rd_data` unchanged.
- R5: `almost_empty_n` is 0 when the stored count is at most the empty offset, and 1 above it. The default offset is 8.
- R6: `almost_full_n` is 0 when the free space (2048 minus the stored count) is at most the full offset, and 1 above it. The default offset is 8.
- R7: With `load_mode`=2'b01 during reset, the first accepted write sets the empty offset from `wr_data[10:0]`. The second accepted write sets the full offset the same way. Neither of these two words is stored.
- R8: With `load_mode`=2'b10 during reset, `in_ready` stays 0 until 22 bits have been shifted in. A bit is taken from `ser_bit` on each write-clock edge where `ser_en` is high. The first 11 bits are the empty offset, then 11 bits for the full offset, each most significant bit first.
- R9: The first read-clock edge with `rtx_hold` high marks the current read position. While `rtx_hold` stays high, a read-clock edge with `rtx_go` high rewinds the read position to the mark, so the words from the mark onward are read again.
- R10: While the mark is held, the write side counts occupancy from the mark rather than from the read position. After `rtx_hold` falls, the space freed by reads past the mark is given back.
- R11: When `rtx_go` (with an active mark) and a read fall on the same edge, the rewind wins and the read is dropped: `rd_data` is unchanged.
- R12: Each pointer sent across a clock boundary changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-port clock |
| clk_b | input | 1 | Read-port clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| load_mode | input | 2 | Offset source, sampled during reset: 00 default, 01 parallel, 10 serial |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write data |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| in_ready | output | 1 | Write accepted when high |
| almost_full_n | output | 1 | Active-low almost-full flag |
| rd_en | input | 1 | Read enable |
| rtx_hold | input | 1 | Mark and hold the replay position |
| rtx_go | input | 1 | Rewind the read position to the mark |
| rd_data | output | 36 | Read data, updated on a read |
| out_ready | output | 1 | A word is available to read |
| almost_empty_n | output | 1 | Active-low almost-empty flag |

## Verification
A rewind request and an ordinary read can land on the same read-clock edge. The bench provokes this by raising `rtx_go` and `rd_en` together after three words have been read past a held mark. The pass condition has two parts: `rd_data` still shows the last word read on the edge after the collision, and the next reads restart at the marked word. A second overlap is between a held mark and continued writing. The bench holds `wr_en` high against a buffer whose reader has moved past the mark. It then counts the accepted writes, which must stop at 2044 rather than 2048.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DCF_DATA_W     = 36;
    localparam int DCF_ADDR_W     = 11;
    localparam int DCF_DEF_OFFSET = 8;

    typedef enum logic [1:0] {
        LOAD_DEFAULT  = 2'b00,
        LOAD_PARALLEL = 2'b01,
        LOAD_SERIAL   = 2'b10
    } load_mode_e;

    typedef enum logic [1:0] {
        CFG_RUN,
        CFG_PAR_EMPTY,
        CFG_PAR_FULL,
        CFG_SHIFT
    } cfg_state_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d_async;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 36,
    parameter int AW = 11
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW      = 11,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  load_mode_e    mode,
    input  logic          wr_en,
    input  logic [AW-1:0] din_ofs,
    input  logic          ser_en,
    input  logic          ser_bit,
    input  logic [AW:0]   prot_gray_async,
    output logic          in_ready,
    output logic          almost_full_n,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   wr_gray,
    output logic [AW-1:0] ae_ofs
);
    localparam int PW       = AW + 1;
    localparam int DEPTH    = 1 << AW;
    localparam int SER_BITS = 2 * AW;
    localparam int CW       = $clog2(SER_BITS + 1);

    logic [PW-1:0]       prot_gray_s, prot_bin, wr_ptr, wr_next, used_next, free_next;
    logic [AW-1:0]       af_ofs, ae_ofs_n, af_ofs_n;
    logic [SER_BITS-2:0] sr, sr_n;
    logic [SER_BITS-1:0] shifted;
    logic [CW-1:0]       cnt, cnt_n;
    cfg_state_e          st, st_n;
    logic                fire, store;

    dcf_sync #(.W(PW)) u_prot_sync (
        .clk(clk), .rst(rst), .d_async(prot_gray_async), .q(prot_gray_s)
    );

    assign prot_bin  = PW'(gray2bin(32'(prot_gray_s)));
    assign fire      = wr_en & in_ready;
    assign store     = fire & (st == CFG_RUN);
    assign wr_next   = wr_ptr + PW'(store);
    assign used_next = wr_next - prot_bin;
    assign free_next = PW'(DEPTH) - used_next;
    assign shifted   = {sr, ser_bit};
    assign mem_we    = store;
    assign mem_addr  = wr_ptr[AW-1:0];

    always_comb begin
        st_n     = st;
        ae_ofs_n = ae_ofs;
        af_ofs_n = af_ofs;
        sr_n     = sr;
        cnt_n    = cnt;
        unique case (st)
            CFG_PAR_EMPTY: if (fire) begin
                ae_ofs_n = din_ofs;
                st_n     = CFG_PAR_FULL;
            end
            CFG_PAR_FULL: if (fire) begin
                af_ofs_n = din_ofs;
                st_n     = CFG_RUN;
            end
            CFG_SHIFT: if (ser_en) begin
                sr_n  = shifted[SER_BITS-2:0];
                cnt_n = cnt + 1'b1;
                if (cnt == CW'(SER_BITS - 1)) begin
                    ae_ofs_n = shifted[SER_BITS-1:AW];
                    af_ofs_n = shifted[AW-1:0];
                    st_n     = CFG_RUN;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr        <= '0;
            wr_gray       <= '0;
            in_ready      <= 1'b0;
            almost_full_n <= 1'b1;
            ae_ofs        <= AW'(DEF_OFS);
            af_ofs        <= AW'(DEF_OFS);
            sr            <= '0;
            cnt           <= '0;
            unique case (mode)
                LOAD_PARALLEL: st <= CFG_PAR_EMPTY;
                LOAD_SERIAL:   st <= CFG_SHIFT;
                default:       st <= CFG_RUN;
            endcase
        end else begin
            wr_ptr        <= wr_next;
            wr_gray       <= PW'(bin2gray(32'(wr_next)));
            in_ready      <= (st_n != CFG_SHIFT) && (used_next != PW'(DEPTH));
            almost_full_n <= free_next > PW'(af_ofs_n);
            st            <= st_n;
            ae_ofs        <= ae_ofs_n;
            af_ofs        <= af_ofs_n;
            sr            <= sr_n;
            cnt           <= cnt_n;
        end
    end

    assert_shift_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
        (st == CFG_SHIFT) |-> !in_ready);

    assert_write_advances_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_ready && st == CFG_RUN) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> ((wr_ptr - prot_bin) < PW'(DEPTH)));

    assert_wr_gray_step_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          rtx_hold,
    input  logic          rtx_go,
    input  logic [AW:0]   wr_gray_async,
    input  logic [AW-1:0] ae_ofs,
    output logic          out_ready,
    output logic          almost_empty_n,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   prot_gray
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray_s, wr_bin, rd_ptr, rd_next, mark, prot, prot_next, target, cnt_next;
    logic          mark_act, replay, fire;

    dcf_sync #(.W(PW)) u_wr_sync (
        .clk(clk), .rst(rst), .d_async(wr_gray_async), .q(wr_gray_s)
    );

    assign wr_bin    = PW'(gray2bin(32'(wr_gray_s)));
    assign replay    = rtx_go & mark_act;
    assign fire      = rd_en & out_ready & ~replay;
    assign rd_next   = replay ? mark : rd_ptr + PW'(fire);
    assign cnt_next  = wr_bin - rd_next;
    assign target    = mark_act ? mark : rd_ptr;
    assign prot_next = (prot != target) ? prot + 1'b1 : prot;
    assign mem_re    = fire;
    assign mem_addr  = rd_ptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr         <= '0;
            prot           <= '0;
            prot_gray      <= '0;
            mark           <= '0;
            mark_act       <= 1'b0;
            out_ready      <= 1'b0;
            almost_empty_n <= 1'b0;
        end else begin
            rd_ptr         <= rd_next;
            prot           <= prot_next;
            prot_gray      <= PW'(bin2gray(32'(prot_next)));
            out_ready      <= cnt_next != '0;
            almost_empty_n <= cnt_next > PW'(ae_ofs);
            if (!rtx_hold) begin
                mark_act <= 1'b0;
            end else if (!mark_act) begin
                mark_act <= 1'b1;
                mark     <= rd_ptr;
            end
        end
    end

    assert_replay_rewinds_R9: assert property (@(posedge clk) disable iff (rst)
        (rtx_go && mark_act) |=> (rd_ptr == $past(mark)));

    assert_mark_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (mark_act && rtx_hold) |=> $stable(mark));

    assert_prot_gray_step_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(prot_gray ^ $past(prot_gray)));
endmodule

// File: rtl/dcfifo_rtx.sv
module dcfifo_rtx
    import dcf_pkg::*;
#(
    parameter int DATA_W  = DCF_DATA_W,
    parameter int ADDR_W  = DCF_ADDR_W,
    parameter int DEF_OFS = DCF_DEF_OFFSET
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst,
    input  logic [1:0]        load_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_en,
    input  logic              ser_bit,
    output logic              in_ready,
    output logic              almost_full_n,
    input  logic              rd_en,
    input  logic              rtx_hold,
    input  logic              rtx_go,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready,
    output logic              almost_empty_n
);
    localparam int PW = ADDR_W + 1;

    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] waddr, raddr, ae_ofs;
    logic [PW-1:0]     wr_gray, prot_gray;

    dcf_wr_ctrl #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
        .clk(clk_a), .rst(rst), .mode(load_mode_e'(load_mode)),
        .wr_en(wr_en), .din_ofs(wr_data[ADDR_W-1:0]),
        .ser_en(ser_en), .ser_bit(ser_bit),
        .prot_gray_async(prot_gray),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .mem_we(mem_we), .mem_addr(waddr), .wr_gray(wr_gray), .ae_ofs(ae_ofs)
    );

    dcf_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk(clk_b), .rst(rst), .rd_en(rd_en),
        .rtx_hold(rtx_hold), .rtx_go(rtx_go),
        .wr_gray_async(wr_gray), .ae_ofs(ae_ofs),
        .out_ready(out_ready), .almost_empty_n(almost_empty_n),
        .mem_re(mem_re), .mem_addr(raddr), .prot_gray(prot_gray)
    );

    dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wclk(clk_a), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rclk(clk_b), .rrst(rst), .re(mem_re), .raddr(raddr), .rdata(rd_data)
    );

    assert_idle_read_holds_R4: assert property (@(posedge clk_b) disable iff (rst)
        (rd_en && !out_ready) |=> $stable(rd_data));
endmodule

// File: tb/tb_dcfifo_rtx.sv
`timescale 1ns/1ps
module tb_dcfifo_rtx;
    logic        clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
    logic [1:0]  load_mode = 2'b00;
    logic        wr_en = 1'b0, ser_en = 1'b0, ser_bit = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0, rtx_hold = 1'b0, rtx_go = 1'b0;
    logic        in_ready, almost_full_n, out_ready, almost_empty_n;
    logic [35:0] rd_data;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk_a = ~clk_a;
    always #3 clk_b = ~clk_b;

    dcfifo_rtx dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .load_mode(load_mode),
        .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_bit(ser_bit),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .rd_en(rd_en), .rtx_hold(rtx_hold), .rtx_go(rtx_go),
        .rd_data(rd_data), .out_ready(out_ready), .almost_empty_n(almost_empty_n)
    );

    function automatic logic [35:0] word(input int i);
        return {4'h5, 32'(i * 32'h0101_0007 + 3)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk_b);
        repeat (8) @(negedge clk_a);
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk_a);
        rst = 1'b1; load_mode = mode;
        repeat (6) @(negedge clk_b);
        @(negedge clk_a);
        rst = 1'b0;
        load_mode = 2'b00;
    endtask

    task automatic write_one(input logic [35:0] v);
        @(negedge clk_a);
        while (!in_ready) @(negedge clk_a);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk_a);
        wr_en = 1'b0;
    endtask

    task automatic read_one(input logic [35:0] exp, input string req);
        @(negedge clk_b);
        while (!out_ready) @(negedge clk_b);
        rd_en = 1'b1;
        @(negedge clk_b);
        rd_en = 1'b0;
        chk(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk_a); rst = 1'b1;
        repeat (6) @(negedge clk_b);
        chk("R1 in_ready in reset", 64'(in_ready), 0);
        chk("R1 out_ready in reset", 64'(out_ready), 0);
        chk("R1 almost_empty_n in reset", 64'(almost_empty_n), 0);
        chk("R1 almost_full_n in reset", 64'(almost_full_n), 1);
        @(negedge clk_a); rst = 1'b0;
        settle();
        chk("R1 in_ready after reset", 64'(in_ready), 1);
    endtask

    task automatic t_order();
        do_reset(2'b00);
        for (int i = 0; i < 10; i++) write_one(word(i));
        settle();
        chk("R5 almost_empty_n with 10 words", 64'(almost_empty_n), 1);
        read_one(word(0), "R2 order");
        read_one(word(1), "R2 order");
        settle();
        chk("R5 almost_empty_n with 8 words", 64'(almost_empty_n), 0);
        for (int i = 2; i < 10; i++) read_one(word(i), "R2 order");
        settle();
        chk("R4 out_ready when empty", 64'(out_ready), 0);
        @(negedge clk_b); rd_en = 1'b1;
        repeat (3) @(negedge clk_b);
        rd_en = 1'b0;
        chk("R4 read while empty keeps rd_data", 64'(rd_data), 64'(word(9)));
    endtask

    task automatic t_full();
        do_reset(2'b00);
        for (int i = 0; i < 2039; i++) write_one(word(i));
        settle();
        chk("R6 almost_full_n with free 9", 64'(almost_full_n), 1);
        write_one(word(2039));
        settle();
        chk("R6 almost_full_n with free 8", 64'(almost_full_n), 0);
        for (int i = 2040; i < 2048; i++) write_one(word(i));
        settle();
        chk("R3 in_ready when full", 64'(in_ready), 0);
        @(negedge clk_a); wr_en = 1'b1; wr_data = 36'hD_EADB_EEF0;
        repeat (4) @(negedge clk_a);
        wr_en = 1'b0;
        for (int i = 0; i < 2048; i++) read_one(word(i), "R3 full contents");
        settle();
        chk("R3 write when full ignored", 64'(out_ready), 0);
    endtask

    task automatic t_parallel();
        do_reset(2'b01);
        settle();
        write_one(36'd3);
        write_one(36'd5);
        for (int i = 0; i < 4; i++) write_one(word(100 + i));
        settle();
        chk("R7 empty offset 3 with 4 words", 64'(almost_empty_n), 1);
        read_one(word(100), "R7 offset words not stored");
        settle();
        chk("R7 empty offset 3 with 3 words", 64'(almost_empty_n), 0);
        for (int i = 0; i < 2039; i++) write_one(word(i));
        settle();
        chk("R7 full offset 5 with free 6", 64'(almost_full_n), 1);
        write_one(word(7));
        settle();
        chk("R7 full offset 5 with free 5", 64'(almost_full_n), 0);
    endtask

    task automatic t_serial();
        logic [21:0] bits;
        bits = {11'd2, 11'd4};
        do_reset(2'b10);
        settle();
        chk("R8 in_ready low before shift", 64'(in_ready), 0);
        for (int i = 21; i >= 1; i--) begin
            @(negedge clk_a); ser_en = 1'b1; ser_bit = bits[i];
        end
        @(negedge clk_a); ser_en = 1'b0;
        repeat (3) @(negedge clk_a);
        chk("R8 in_ready low after 21 bits", 64'(in_ready), 0);
        @(negedge clk_a); ser_en = 1'b1; ser_bit = bits[0];
        @(negedge clk_a); ser_en = 1'b0;
        settle();
        chk("R8 in_ready after 22 bits", 64'(in_ready), 1);
        for (int i = 0; i < 3; i++) write_one(word(i));
        settle();
        chk("R8 empty offset 2 with 3 words", 64'(almost_empty_n), 1);
        read_one(word(0), "R8 data after serial load");
        settle();
        chk("R8 empty offset 2 with 2 words", 64'(almost_empty_n), 0);
    endtask

    task automatic t_replay();
        do_reset(2'b00);
        for (int i = 0; i < 6; i++) write_one(word(i));
        settle();
        @(negedge clk_b); rtx_hold = 1'b1;
        repeat (2) @(negedge clk_b);
        for (int i = 0; i < 3; i++) read_one(word(i), "R9 before rewind");
        @(negedge clk_b); rd_en = 1'b1; rtx_go = 1'b1;
        @(negedge clk_b); rd_en = 1'b0; rtx_go = 1'b0;
        chk("R11 rewind beats read", 64'(rd_data), 64'(word(2)));
        for (int i = 0; i < 6; i++) read_one(word(i), "R9 replayed word");
        @(negedge clk_b); rtx_hold = 1'b0;
        settle();
    endtask

    task automatic t_protect();
        int acc;
        acc = 0;
        do_reset(2'b00);
        settle();
        @(negedge clk_b); rtx_hold = 1'b1;
        settle();
        for (int i = 0; i < 4; i++) write_one(word(i));
        for (int i = 0; i < 4; i++) read_one(word(i), "R10 reads past mark");
        settle();
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk_a);
            wr_en = 1'b1; wr_data = word(i);
            if (in_ready) acc++;
        end
        @(negedge clk_a); wr_en = 1'b0;
        chk("R10 writes accepted under mark", 64'(acc), 2044);
        @(negedge clk_b); rtx_hold = 1'b0;
        settle();
        chk("R10 space returned after release", 64'(in_ready), 1);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_order();
        t_full();
        t_parallel();
        t_serial();
        t_replay();
        t_protect();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule